// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Byte Codec

This block protects one byte with a Hamming single-error-correcting code. The encoder half turns an 8-bit data byte into a 12-bit code word. The decoder half takes a 12-bit word that may have been corrupted in storage or transit. It works out which parity checks fail and repairs the one bit that the failing checks point to. It returns the repaired data byte, the repaired word, an error flag, the bit position that was fixed, and a flag for patterns that cannot be corrected.

Code word positions are numbered 1 to 12. In the port vectors, position p is held in bit p-1. Check bits occupy the positions that are powers of two. The data bits fill the positions between them. Because of this layout, the syndrome read as a binary number is the position of the faulty bit. Both halves share one output stage. With `REG_OUT=1` (the default), that stage is a register bank with a valid bit that trails the input valid by one clock. With `REG_OUT=0` the outputs follow the inputs combinationally.

Top module: `ham_sec_codec`

## Requirements
- R1: Positions 1, 2, 4 and 8 carry check bits. Data bits 7 down to 0 go to positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order, and position p is vector bit p-1.
- R2: Each check bit at position 2^k makes even the parity of every position whose index has bit k set, including the check bit itself. Data 8'h9A encodes to 12'h54E, which reads 011100101010 from position 1 to position 12.
- R3: Syndrome bit k is 1 when the group of check k has odd parity. A nonzero syndrome from 1 to 12 flips that position, raises the error flag and reports the syndrome on the position output. For example, 12'h74E (position 10 flipped) gives position 10, data 8'h9A and code 12'h54E.
- R4: When every check passes, the word and its data pass through unchanged, with the error flag, uncorrectable flag and position all 0.
- R5: A syndrome of 1, 2, 4 or 8 repairs only that check bit. The data output equals the data held in the received word.
- R6: A syndrome of 13, 14 or 15 raises both the uncorrectable flag and the error flag. It reports position 0, and the word and its data pass through uncorrected.
- R7: With registered outputs, each output valid is its input valid delayed by one clock, and results appear in the cycle after the input was presented.
- R8: Synchronous active-high reset clears both valid outputs and every payload output to 0.
- R9: With registered outputs, payload outputs load only in a cycle whose input valid is high. Otherwise they hold their previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Encoder input qualifier |
| enc_data_i | input | 8 | Byte to encode |
| enc_valid_o | output | 1 | Encoder output qualifier |
| enc_code_o | output | 12 | Encoded word, position p at bit p-1 |
| dec_valid_i | input | 1 | Decoder input qualifier |
| dec_code_i | input | 12 | Received word, position p at bit p-1 |
| dec_valid_o | output | 1 | Decoder output qualifier |
| dec_data_o | output | 8 | Repaired data byte |
| dec_code_o | output | 12 | Repaired word |
| dec_err_o | output | 1 | Nonzero syndrome seen |
| dec_uncorr_o | output | 1 | Syndrome points past position 12 |
| dec_pos_o | output | 4 | Position repaired, 0 if none |

## Verification
The hardest case to reach is a syndrome above 12. A single flipped bit can never produce one, so it shows up only for certain multi-bit corruptions. The stimulus reaches it in two ways. First, directed pairs flip position 12 together with position 1, 2 or 3, which gives syndromes 13, 14 and 15. Second, the random loop injects a random double flip in about a third of its transactions. Check-bit-only errors are also driven directly, to show that a repair at positions 1, 2, 4 and 8 leaves the data byte unchanged.

// File: rtl/ham_pkg.sv
package ham_pkg;
    localparam int DATA_W = 8;
    localparam int PAR_W  = 4;
    localparam int CODE_W = DATA_W + PAR_W;
    localparam int SYN_W  = PAR_W;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SYN_W-1:0]  syn_t;

    typedef struct packed {
        data_t data;
        code_t code;
        logic  err;
        logic  uncorr;
        syn_t  pos;
    } dec_out_t;

    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // scatter data bits, MSB first, over the non-power-of-two positions
    function automatic code_t place_data(input data_t d);
        code_t c;
        int    idx;
        c   = '0;
        idx = DATA_W - 1;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!is_pow2(p)) begin
                c[p-1] = d[idx];
                idx    = idx - 1;
            end
        end
        return c;
    endfunction

    function automatic data_t pick_data(input code_t c);
        data_t d;
        int    idx;
        d   = '0;
        idx = DATA_W - 1;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!is_pow2(p)) begin
                d[idx] = c[p-1];
                idx    = idx - 1;
            end
        end
        return d;
    endfunction

    function automatic syn_t check_bits(input code_t c);
        syn_t s;
        s = '0;
        for (int k = 0; k < PAR_W; k++)
            for (int p = 1; p <= CODE_W; p++)
                if (p[k]) s[k] = s[k] ^ c[p-1];
        return s;
    endfunction

    function automatic code_t encode_word(input data_t d);
        code_t c;
        logic  par;
        c = place_data(d);
        for (int k = 0; k < PAR_W; k++) begin
            par = 1'b0;
            for (int p = 1; p <= CODE_W; p++)
                if (p[k] && p != (1 << k)) par = par ^ c[p-1];
            c[(1 << k) - 1] = par;
        end
        return c;
    endfunction
endpackage

// File: rtl/ham_encoder.sv
module ham_encoder
    import ham_pkg::*;
(
    input  data_t data_i,
    output code_t code_o
);
    assign code_o = encode_word(data_i);
endmodule

// File: rtl/ham_syndrome.sv
module ham_syndrome
    import ham_pkg::*;
(
    input  code_t code_i,
    output syn_t  syn_o
);
    assign syn_o = check_bits(code_i);
endmodule

// File: rtl/ham_corrector.sv
module ham_corrector
    import ham_pkg::*;
(
    input  code_t    code_i,
    input  syn_t     syn_i,
    output dec_out_t res_o
);
    code_t fixed;
    logic  in_range;

    always_comb begin
        in_range = (int'(syn_i) <= CODE_W);
        fixed    = code_i;
        if (syn_i != '0 && in_range)
            fixed[int'(syn_i) - 1] = ~code_i[int'(syn_i) - 1];
        res_o.code   = fixed;
        res_o.data   = pick_data(fixed);
        res_o.err    = (syn_i != '0);
        res_o.uncorr = (syn_i != '0) && !in_range;
        res_o.pos    = (syn_i != '0 && in_range) ? syn_i : '0;
    end
endmodule

// File: rtl/ham_sec_codec.sv
module ham_sec_codec
    import ham_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enc_valid_i,
    input  logic [DATA_W-1:0]   enc_data_i,
    output logic                enc_valid_o,
    output logic [CODE_W-1:0]   enc_code_o,
    input  logic                dec_valid_i,
    input  logic [CODE_W-1:0]   dec_code_i,
    output logic                dec_valid_o,
    output logic [DATA_W-1:0]   dec_data_o,
    output logic [CODE_W-1:0]   dec_code_o,
    output logic                dec_err_o,
    output logic                dec_uncorr_o,
    output logic [SYN_W-1:0]    dec_pos_o
);
    code_t    enc_word;
    syn_t     syn;
    dec_out_t dec_res;
    dec_out_t dec_q;

    ham_encoder   u_enc (.data_i(enc_data_i), .code_o(enc_word));
    ham_syndrome  u_syn (.code_i(dec_code_i), .syn_o(syn));
    ham_corrector u_cor (.code_i(dec_code_i), .syn_i(syn), .res_o(dec_res));

    generate
        if (REG_OUT) begin : g_reg
            logic  enc_v_q, dec_v_q;
            code_t enc_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    enc_v_q <= 1'b0;
                    dec_v_q <= 1'b0;
                    enc_q   <= '0;
                    dec_q   <= '0;
                end else begin
                    enc_v_q <= enc_valid_i;
                    dec_v_q <= dec_valid_i;
                    if (enc_valid_i) enc_q <= enc_word;
                    if (dec_valid_i) dec_q <= dec_res;
                end
            end
            assign enc_valid_o = enc_v_q;
            assign enc_code_o  = enc_q;
            assign dec_valid_o = dec_v_q;

            assert_enc_lag_R7: assert property (@(posedge clk) disable iff (rst)
                enc_valid_i |=> enc_valid_o);
            assert_dec_lag_R7: assert property (@(posedge clk) disable iff (rst)
                !dec_valid_i |=> !dec_valid_o);
            assert_dec_hold_R9: assert property (@(posedge clk) disable iff (rst)
                !dec_valid_i |=> $stable(dec_code_o));
        end else begin : g_comb
            assign enc_valid_o = enc_valid_i;
            assign enc_code_o  = enc_word;
            assign dec_valid_o = dec_valid_i;
            assign dec_q       = dec_res;
        end
    endgenerate

    assign dec_data_o   = dec_q.data;
    assign dec_code_o   = dec_q.code;
    assign dec_err_o    = dec_q.err;
    assign dec_uncorr_o = dec_q.uncorr;
    assign dec_pos_o    = dec_q.pos;

    // encoder output must satisfy every check of the decoder side
    assert_enc_clean_R2: assert property (@(posedge clk) disable iff (rst)
        enc_valid_o |-> (check_bits(enc_code_o) == '0));
    // a repaired word is a legal code word
    assert_fix_clean_R3: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_o && !dec_uncorr_o) |-> (check_bits(dec_code_o) == '0));
    assert_pos_range_R3: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_o && dec_err_o && !dec_uncorr_o) |->
            (dec_pos_o != '0 && int'(dec_pos_o) <= CODE_W));
    assert_uncorr_flags_R6: assert property (@(posedge clk) disable iff (rst)
        dec_uncorr_o |-> (dec_err_o && dec_pos_o == '0));
    assert_clean_pos_R4: assert property (@(posedge clk) disable iff (rst)
        !dec_err_o |-> (dec_pos_o == '0 && !dec_uncorr_o));
endmodule

// File: tb/ham_sec_codec_tb.sv
`timescale 1ns/1ps
module ham_sec_codec_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_valid_i = 1'b0;
    logic [7:0]  enc_data_i = '0;
    logic        enc_valid_o;
    logic [11:0] enc_code_o;
    logic        dec_valid_i = 1'b0;
    logic [11:0] dec_code_i = '0;
    logic        dec_valid_o;
    logic [7:0]  dec_data_o;
    logic [11:0] dec_code_o;
    logic        dec_err_o;
    logic        dec_uncorr_o;
    logic [3:0]  dec_pos_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    ham_sec_codec u_dut (
        .clk(clk), .rst(rst),
        .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
        .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
        .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
        .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
        .dec_code_o(dec_code_o), .dec_err_o(dec_err_o),
        .dec_uncorr_o(dec_uncorr_o), .dec_pos_o(dec_pos_o)
    );

    // R1: data bit i lands at this 1-based position
    function automatic int dpos(input int i);
        case (i)
            7: return 3;  6: return 5;  5: return 6;  4: return 7;
            3: return 9;  2: return 10; 1: return 11; default: return 12;
        endcase
    endfunction

    function automatic logic [11:0] m_enc(input logic [7:0] d);
        logic [11:0] c = '0;
        for (int i = 0; i < 8; i++) c[dpos(i)-1] = d[i];
        for (int k = 0; k < 4; k++) begin
            logic x = 1'b0;
            for (int p = 1; p <= 12; p++) if (((p >> k) & 1) == 1) x ^= c[p-1];
            c[(1 << k) - 1] = x;
        end
        return c;
    endfunction

    function automatic logic [3:0] m_syn(input logic [11:0] c);
        logic [3:0] s = '0;
        for (int p = 1; p <= 12; p++) if (c[p-1]) s ^= 4'(p);
        return s;
    endfunction

    function automatic logic [7:0] m_data(input logic [11:0] c);
        logic [7:0] d;
        for (int i = 0; i < 8; i++) d[i] = c[dpos(i)-1];
        return d;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xact(input logic [7:0] d, input logic [11:0] c, input string req);
        logic [3:0]  s;
        logic [11:0] ec;
        logic [7:0]  ed;
        logic        eu;
        logic [3:0]  ep;
        s  = m_syn(c);
        ec = c;
        eu = (s > 4'd12);
        ep = (s != 0 && !eu) ? s : 4'd0;
        if (ep != 0) ec[ep-1] = ~ec[ep-1];
        ed = m_data(ec);
        @(negedge clk);
        enc_valid_i = 1'b1; enc_data_i = d;
        dec_valid_i = 1'b1; dec_code_i = c;
        @(negedge clk);
        enc_valid_i = 1'b0; enc_data_i = ~d;
        dec_valid_i = 1'b0; dec_code_i = ~c;
        chk(enc_valid_o == 1'b1, {req, " R7 enc valid"}, 32'(enc_valid_o), 1);
        chk(dec_valid_o == 1'b1, {req, " R7 dec valid"}, 32'(dec_valid_o), 1);
        chk(enc_code_o == m_enc(d), {req, " R2 encode"}, 32'(enc_code_o), 32'(m_enc(d)));
        chk(dec_code_o == ec, {req, " R3 code"}, 32'(dec_code_o), 32'(ec));
        chk(dec_data_o == ed, {req, " R3 data"}, 32'(dec_data_o), 32'(ed));
        chk(dec_err_o == (s != 0), {req, " R3 err"}, 32'(dec_err_o), 32'(s != 0));
        chk(dec_uncorr_o == eu, {req, " R6 uncorr"}, 32'(dec_uncorr_o), 32'(eu));
        chk(dec_pos_o == ep, {req, " R3 pos"}, 32'(dec_pos_o), 32'(ep));
        @(negedge clk);
        chk(dec_valid_o == 1'b0 && enc_valid_o == 1'b0, {req, " R7 valid drop"},
            32'({enc_valid_o, dec_valid_o}), 0);
        chk(dec_code_o == ec && enc_code_o == m_enc(d), {req, " R9 hold"},
            32'(dec_code_o), 32'(ec));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(!enc_valid_o && !dec_valid_o, "R8 valids", 32'({enc_valid_o, dec_valid_o}), 0);
        chk(enc_code_o == 0 && dec_code_o == 0 && dec_data_o == 0, "R8 payload",
            32'(dec_code_o), 0);
        chk(!dec_err_o && !dec_uncorr_o && dec_pos_o == 0, "R8 flags", 32'(dec_pos_o), 0);
        rst = 1'b0;
        // R1 R2 known example
        xact(8'h9A, 12'h54E, "R1 example");
        chk(enc_code_o == 12'h54E, "R2 literal", 32'(enc_code_o), 32'h54E);
        // R3 position 10 flipped
        xact(8'h9A, 12'h74E, "R3 example");
        chk(dec_pos_o == 4'd10 && dec_data_o == 8'h9A, "R3 literal pos10",
            32'({dec_pos_o, dec_data_o}), 32'hA9A);
        // R4 clean words
        xact(8'h00, m_enc(8'h00), "R4 zero");
        xact(8'hFF, m_enc(8'hFF), "R4 ones");
        // R5 check-bit-only errors keep data
        for (int k = 0; k < 4; k++) begin
            logic [11:0] w = m_enc(8'hC3) ^ (12'h1 << ((1 << k) - 1));
            xact(8'hC3, w, "R5 parity pos");
            chk(dec_data_o == 8'hC3, "R5 data kept", 32'(dec_data_o), 32'hC3);
        end
        // R6 syndromes 13, 14, 15
        xact(8'h5A, m_enc(8'h5A) ^ 12'h801, "R6 syn13");
        chk(dec_uncorr_o && dec_code_o == (m_enc(8'h5A) ^ 12'h801), "R6 pass13",
            32'(dec_code_o), 32'(m_enc(8'h5A) ^ 12'h801));
        xact(8'h5A, m_enc(8'h5A) ^ 12'h802, "R6 syn14");
        xact(8'h5A, m_enc(8'h5A) ^ 12'h804, "R6 syn15");
        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [7:0]  d = 8'($urandom);
            logic [11:0] w = m_enc(d);
            int mode = $urandom_range(0, 2);
            if (mode >= 1) w[$urandom_range(0, 11)] ^= 1'b1;
            if (mode == 2) w[$urandom_range(0, 11)] ^= 1'b1;
            xact(d, w, "R3 random");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule